// File: doc/BRIEF.md
# CAN Controller Sleep-Mode Manager

This block runs the low-power states of a CAN controller. It holds the 8-bit mode control register and tracks two states: halt and sleep. It allows sleep to start only from halt, and only through a single write that moves the controller from halt into sleep. Sleep ends when software clears the sleep bit. If automatic wake-up is enabled, a dominant bit seen on the bus also ends sleep.

After sleep ends, the controller must not take part in bus traffic at once. The block first waits for a run of consecutive recessive bit times, so the frame that caused a wake-up is lost by design. While asleep, the block freezes the error-counter values it presents. It also restricts the host to four registers: mode control, general status, interrupt request and interrupt mask. Reads of any other register return zero, and writes to them are not passed on.

The host register port is a single-cycle request with an address. Bus input arrives as one sampled bit qualified by a bit-time strobe.

Top module: `can_sleep_ctrl`

## Requirements
- R1: Mode control register (MCR) bit 1 is halt, bit 5 is sleep and bit 7 is auto-wake. A write to address 0 enters sleep only when halt is already set and the written value has bit 5 = 1 and bit 1 = 0. After such a write, sleep_o = 1 and halt_o = 0 from the next cycle. While awake, a write with bit 5 = 0 sets halt_o to the written bit 1.
- R2: A write that sets bit 5 while not asleep, but not halted or with bit 1 = 1, leaves halt_o and sleep_o unchanged. It also sets illegal_o, which stays high until reset.
- R3: The register resets to 0x00. While asleep, a write with bit 5 = 0 ends sleep on the next cycle.
- R4: When asleep with bit 7 set, a strobed dominant bit (bus_bit_i = 0 with bit_tick_i = 1) clears sleep on the next cycle. This holds even when a register write in the same cycle keeps bit 5 = 1.
- R5: When asleep with bit 7 clear, bus input has no effect: sleep_o stays high and bus_en_o stays low.
- R6: bus_en_o is high only when the controller is neither asleep, nor halted, nor resynchronising. After any exit from sleep, bus_en_o stays low until 11 consecutive strobed recessive bits are seen. A strobed dominant bit restarts the count.
- R7: While awake, rec_o and tec_o follow rec_i and tec_i one cycle later. While asleep, they hold their values.
- R8: While asleep, only addresses 0 to 3 (mode control, general status, interrupt request, interrupt mask) are accessible. For any other address, access_ok_o is low, reg_rdata_o is 0 and ext_we_o stays low.
- R9: MCR bits 4 and 3 always read as 0. The other bits read back as stored.
- R10: While awake, every address is accessible. Reads from addresses other than 0 return ext_rdata_i, and writes to them pulse ext_we_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Register access request, one cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Register address (0 = mode control) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| access_ok_o | output | 1 | Requested access is permitted |
| ext_rdata_i | input | 8 | Read data from the rest of the controller |
| ext_we_o | output | 1 | Permitted write to a non-mode register |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| bit_tick_i | input | 1 | Bit-time strobe |
| rec_i | input | CNT_W | Receive error counter |
| tec_i | input | CNT_W | Transmit error counter |
| rec_o | output | CNT_W | Receive error counter, held while asleep |
| tec_o | output | CNT_W | Transmit error counter, held while asleep |
| halt_o | output | 1 | Halt state |
| sleep_o | output | 1 | Sleep state |
| bus_en_o | output | 1 | Bus participation allowed |
| illegal_o | output | 1 | Sticky illegal sleep request |

## Verification
A host write to the mode register can arrive in the same cycle as a strobed dominant bit that wakes the block. The bench provokes this by enabling auto-wake, entering sleep, and then driving, in one cycle, a write that keeps the sleep bit set together with a dominant strobe. The wake-up must win: sleep_o must be low on the next cycle, the register must read back with bit 5 clear, and bus_en_o must stay low until the recessive run is complete.

// File: rtl/can_sleep_pkg.sv
package can_sleep_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned BIT_HALT = 1;
  localparam int unsigned BIT_SLP  = 5;
  localparam int unsigned BIT_AWK  = 7;
  localparam logic [DATA_W-1:0] RSVD_MASK = 8'h18;
  localparam logic [DATA_W-1:0] MODE_MASK = 8'h22;

  localparam int unsigned MCR_ADDR = 0;
  localparam int unsigned OPEN_N   = 4;
  // mode control, general status, interrupt request, interrupt mask
  localparam int unsigned OPEN_ADDR [OPEN_N] = '{0, 1, 2, 3};
endpackage

// File: rtl/can_sleep_mode.sv
module can_sleep_mode
  import can_sleep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bus_bit_i,
  input  logic              bit_tick_i,
  output logic [DATA_W-1:0] mcr_o,
  output logic              exit_o,
  output logic              illegal_o
);
  logic [DATA_W-1:0] mcr_q, mcr_d;
  logic              ill_q, ill_d;
  logic              asleep, halted;

  assign asleep = mcr_q[BIT_SLP];
  assign halted = mcr_q[BIT_HALT];

  always_comb begin
    mcr_d = mcr_q;
    ill_d = ill_q;
    if (wr_i) begin
      mcr_d = (wdata_i & ~RSVD_MASK & ~MODE_MASK) | (mcr_q & MODE_MASK);
      if (asleep) begin
        if (!wdata_i[BIT_SLP]) mcr_d[BIT_SLP] = 1'b0;
      end else if (wdata_i[BIT_SLP]) begin
        if (halted && !wdata_i[BIT_HALT]) begin
          mcr_d[BIT_SLP]  = 1'b1;
          mcr_d[BIT_HALT] = 1'b0;
        end else begin
          ill_d = 1'b1;
        end
      end else begin
        mcr_d[BIT_HALT] = wdata_i[BIT_HALT];
      end
    end
    // bus wake-up overrides any host write in the same cycle
    if (asleep && mcr_q[BIT_AWK] && bit_tick_i && !bus_bit_i) mcr_d[BIT_SLP] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcr_q <= '0;
      ill_q <= 1'b0;
    end else begin
      mcr_q <= mcr_d;
      ill_q <= ill_d;
    end
  end

  assign mcr_o     = mcr_q;
  assign exit_o    = asleep && !mcr_d[BIT_SLP];
  assign illegal_o = ill_q;
endmodule

// File: rtl/can_sleep_resync.sv
module can_sleep_resync #(
  parameter int unsigned SYNC_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bus_bit_i,
  input  logic bit_tick_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(SYNC_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(SYNC_BITS - 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (pend_q && bit_tick_i) begin
      if (!bus_bit_i) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = pend_q;
endmodule

// File: rtl/can_sleep_access.sv
module can_sleep_access
  import can_sleep_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              asleep_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mcr_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ok_o,
  output logic              mcr_wr_o,
  output logic              ext_we_o
);
  logic [OPEN_N-1:0] hit;
  logic              is_mcr, allowed;

  for (genvar g = 0; g < OPEN_N; g++) begin : g_open
    assign hit[g] = (addr_i == ADDR_W'(OPEN_ADDR[g]));
  end

  assign is_mcr   = (addr_i == ADDR_W'(MCR_ADDR));
  assign allowed  = !asleep_i || (|hit);
  assign ok_o     = req_i && allowed;
  assign mcr_wr_o = req_i && we_i && is_mcr;
  assign ext_we_o = req_i && we_i && allowed && !is_mcr;

  always_comb begin
    if (is_mcr)       rdata_o = mcr_i & ~RSVD_MASK;
    else if (allowed) rdata_o = ext_rdata_i;
    else              rdata_o = '0;
  end
endmodule

// File: rtl/can_sleep_ctrl.sv
module can_sleep_ctrl
  import can_sleep_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned SYNC_BITS = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              access_ok_o,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic              ext_we_o,
  input  logic              bus_bit_i,
  input  logic              bit_tick_i,
  input  logic [CNT_W-1:0]  rec_i,
  input  logic [CNT_W-1:0]  tec_i,
  output logic [CNT_W-1:0]  rec_o,
  output logic [CNT_W-1:0]  tec_o,
  output logic              halt_o,
  output logic              sleep_o,
  output logic              bus_en_o,
  output logic              illegal_o
);
  logic [DATA_W-1:0] mcr;
  logic              mcr_wr, exit_s, resync_busy;
  logic [CNT_W-1:0]  rec_q, tec_q;

  can_sleep_mode u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (mcr_wr),
    .wdata_i    (reg_wdata_i),
    .bus_bit_i  (bus_bit_i),
    .bit_tick_i (bit_tick_i),
    .mcr_o      (mcr),
    .exit_o     (exit_s),
    .illegal_o  (illegal_o)
  );

  can_sleep_resync #(.SYNC_BITS(SYNC_BITS)) u_resync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (exit_s),
    .bus_bit_i  (bus_bit_i),
    .bit_tick_i (bit_tick_i),
    .busy_o     (resync_busy)
  );

  can_sleep_access #(.ADDR_W(ADDR_W)) u_access (
    .asleep_i    (mcr[BIT_SLP]),
    .req_i       (reg_req_i),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .mcr_i       (mcr),
    .ext_rdata_i (ext_rdata_i),
    .rdata_o     (reg_rdata_o),
    .ok_o        (access_ok_o),
    .mcr_wr_o    (mcr_wr),
    .ext_we_o    (ext_we_o)
  );

  // error counters frozen while asleep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= '0;
      tec_q <= '0;
    end else if (!mcr[BIT_SLP]) begin
      rec_q <= rec_i;
      tec_q <= tec_i;
    end
  end

  assign rec_o    = rec_q;
  assign tec_o    = tec_q;
  assign halt_o   = mcr[BIT_HALT];
  assign sleep_o  = mcr[BIT_SLP];
  assign bus_en_o = !mcr[BIT_SLP] && !mcr[BIT_HALT] && !resync_busy;
endmodule

// File: rtl/can_sleep_ctrl_chk.sv
module can_sleep_ctrl_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_rdata_o,
  input logic              access_ok_o,
  input logic              ext_we_o,
  input logic [CNT_W-1:0]  rec_o,
  input logic [CNT_W-1:0]  tec_o,
  input logic              halt_o,
  input logic              sleep_o,
  input logic              bus_en_o,
  input logic              illegal_o
);
  assert_sleep_from_halt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> ($past(halt_o) && !halt_o));

  assert_illegal_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);

  assert_exit_resyncs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> !bus_en_o);

  assert_no_bus_asleep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !bus_en_o);

  assert_counters_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && $past(sleep_o)) |-> ($stable(rec_o) && $stable(tec_o)));

  assert_blocked_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && reg_req_i && !access_ok_o) |-> (reg_rdata_o == 8'h00 && !ext_we_o));

  assert_open_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_addr_i < ADDR_W'(4)) |-> access_ok_o);

  assert_rsvd_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == '0) |-> (reg_rdata_o[4:3] == 2'b00));

  assert_awake_open_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_o && reg_req_i) |-> access_ok_o);

  assert_ext_we_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_we_o |-> (reg_req_i && reg_we_i));
endmodule

bind can_sleep_ctrl can_sleep_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .access_ok_o (access_ok_o),
  .ext_we_o    (ext_we_o),
  .rec_o       (rec_o),
  .tec_o       (tec_o),
  .halt_o      (halt_o),
  .sleep_o     (sleep_o),
  .bus_en_o    (bus_en_o),
  .illegal_o   (illegal_o)
);

// File: tb/can_sleep_ctrl_bench.sv
module can_sleep_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 8;
  // {pre_write[7:0], test_write[7:0], exp_halt, exp_sleep, exp_illegal}
  localparam logic [18:0] VEC [NV] = '{
    {8'h02, 8'h20, 3'b010},
    {8'h02, 8'h22, 3'b101},
    {8'h00, 8'h20, 3'b001},
    {8'h00, 8'h22, 3'b001},
    {8'h00, 8'h02, 3'b100},
    {8'h02, 8'h00, 3'b000},
    {8'h02, 8'hA0, 3'b010},
    {8'h02, 8'h38, 3'b010}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata, ext_rdata = 8'hAA;
  logic       ok, ext_we;
  logic       bus_bit = 1'b1, tick = 1'b0;
  logic [7:0] rec_in = '0, tec_in = '0, rec_out, tec_out;
  logic       halt, sleep, bus_en, illegal;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  can_sleep_ctrl u_can_sleep_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .access_ok_o(ok), .ext_rdata_i(ext_rdata),
    .ext_we_o(ext_we), .bus_bit_i(bus_bit), .bit_tick_i(tick), .rec_i(rec_in), .tec_i(tec_in),
    .rec_o(rec_out), .tec_o(tec_out), .halt_o(halt), .sleep_o(sleep), .bus_en_o(bus_en),
    .illegal_o(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0; tick = 1'b0; bus_bit = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp,
                    input logic exp_ok);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    chk({tag, " rdata"}, 32'(rdata), 32'(exp));
    chk({tag, " ok"}, 32'(ok), 32'(exp_ok));
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  task automatic bit_time(input logic b);
    @(negedge clk);
    tick = 1'b1; bus_bit = b;
    @(negedge clk);
    tick = 1'b0; bus_bit = 1'b1;
  endtask

  task automatic enter_sleep(input logic [7:0] d);
    wr(4'd0, 8'h02 | (d & 8'h80));
    wr(4'd0, d);
  endtask

  initial begin
    do_reset();
    // reset state, R3
    chk("R3 halt", 32'(halt), 0);
    chk("R3 sleep", 32'(sleep), 0);
    chk("R2 illegal", 32'(illegal), 0);
    chk("R6 bus_en", 32'(bus_en), 1);
    rd("R3 mcr", 4'd0, 8'h00, 1'b1);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(4'd0, VEC[i][18:11]);
      wr(4'd0, VEC[i][10:3]);
      chk(VEC[i][0] ? "R2 halt" : "R1 halt", 32'(halt), 32'(VEC[i][2]));
      chk(VEC[i][0] ? "R2 sleep" : "R1 sleep", 32'(sleep), 32'(VEC[i][1]));
      chk("R2 illegal", 32'(illegal), 32'(VEC[i][0]));
    end

    // R9 reserved bits
    do_reset();
    wr(4'd0, 8'hDD);
    rd("R9 readback", 4'd0, 8'hC5, 1'b1);

    // R10 awake access
    rd("R10 ext read", 4'd5, 8'hAA, 1'b1);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 4'd6; #1;
    chk("R10 ext_we", 32'(ext_we), 1);
    @(negedge clk); req = 1'b0; we = 1'b0;

    // R7, R8, R5, R3, R6: manual exit
    do_reset();
    rec_in = 8'd5; tec_in = 8'd7;
    @(negedge clk);
    chk("R7 rec follow", 32'(rec_out), 5);
    enter_sleep(8'h20);
    chk("R1 sleep", 32'(sleep), 1);
    rec_in = 8'd9; tec_in = 8'd3;
    repeat (3) @(negedge clk);
    chk("R7 rec held", 32'(rec_out), 5);
    chk("R7 tec held", 32'(tec_out), 7);
    rd("R8 blocked", 4'd5, 8'h00, 1'b0);
    rd("R8 open irr", 4'd2, 8'hAA, 1'b1);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 4'd9; wdata = 8'h11; #1;
    chk("R8 no ext_we", 32'(ext_we), 0);
    @(negedge clk); req = 1'b0; we = 1'b0;
    chk("R8 still asleep", 32'(sleep), 1);
    bit_time(1'b0);
    bit_time(1'b0);
    chk("R5 sleep kept", 32'(sleep), 1);
    chk("R5 bus_en", 32'(bus_en), 0);
    wr(4'd0, 8'h00);
    chk("R3 exit", 32'(sleep), 0);
    chk("R6 resync", 32'(bus_en), 0);
    @(negedge clk);
    chk("R7 rec follow again", 32'(rec_out), 9);
    repeat (10) bit_time(1'b1);
    chk("R6 ten bits", 32'(bus_en), 0);
    bit_time(1'b0);
    bit_time(1'b1);
    chk("R6 restart", 32'(bus_en), 0);
    repeat (9) bit_time(1'b1);
    chk("R6 ten after restart", 32'(bus_en), 0);
    bit_time(1'b1);
    chk("R6 joined", 32'(bus_en), 1);

    // R4 auto-wake
    do_reset();
    enter_sleep(8'hA0);
    chk("R4 asleep", 32'(sleep), 1);
    bit_time(1'b0);
    chk("R4 woke", 32'(sleep), 0);
    rd("R4 mcr", 4'd0, 8'h80, 1'b1);
    chk("R4 bus_en", 32'(bus_en), 0);

    // R4 wake and write in same cycle
    do_reset();
    enter_sleep(8'hA0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 4'd0; wdata = 8'hA0; tick = 1'b1; bus_bit = 1'b0;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tick = 1'b0; bus_bit = 1'b1;
    chk("R4 collide sleep", 32'(sleep), 0);
    rd("R4 collide mcr", 4'd0, 8'h80, 1'b1);
    repeat (10) bit_time(1'b1);
    chk("R6 collide wait", 32'(bus_en), 0);
    bit_time(1'b1);
    chk("R6 collide join", 32'(bus_en), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule